// File: doc/BRIEF.md
# PTP Transmit Timestamp Capture Unit

This unit sits beside a transmit packet stream. On the first beat of each packet it reads a 2-bit timestamp request code and a 16-bit client tag. A two-step request stores the tag in an eight-entry queue. Later, when the downstream pipeline reports that the start of that packet has crossed the capture point, the unit latches the 80-bit system timer. It then hands the timer value back with the oldest queued tag on a one-cycle valid strobe.

A one-step request does not queue a tag. It raises a request flag for a later insertion stage, but only when the one-step enable input is set. Any other code leaves the packet alone.

A push into a full queue is a fault, and so is a capture report while the queue is empty. Each fault sets its own status bit. The bit stays set until reset. Only one clock is involved.

Top module: `ptp_tx_stamp`

## Requirements
- R1: While reset is active and in the first cycle after it, `ts_valid`, `onestep_req`, `wr_err` and `rd_err` are all 0.
- R2: `op_code` and `tag_in` are acted on only in a cycle with `pkt_valid`=1 and `pkt_sop`=1. In any other cycle they queue nothing and raise no flag.
- R3: Codes 2'b00 and 2'b11 queue no tag and raise no one-step flag.
- R4: Code 2'b01 with `onestep_en`=1 raises `onestep_req` for exactly the one cycle after the start beat. With `onestep_en`=0 the same code has no effect, and no timestamp results from it.
- R5: Code 2'b10 queues `tag_in`. It does not raise `onestep_req`.
- R6: `cap_pulse` while the queue holds a tag pops that tag. In the next cycle `ts_valid` is 1 for one cycle, `ts_tag` equals the popped tag, and `ts_time` equals the `timer_in` value of the `cap_pulse` cycle. Timer layout: bits 31:0 are nanoseconds and bits 79:32 are seconds.
- R7: The queue holds up to 8 tags, and tags come back in the order they were queued.
- R8: A two-step start beat while 8 tags are queued and no pop occurs in that cycle sets `wr_err`. The tag is discarded.
- R9: `cap_pulse` with an empty queue sets `rd_err` and produces no `ts_valid`.
- R10: `wr_err` and `rd_err` stay 1 until reset, and reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Stream beat valid |
| pkt_sop | input | 1 | First beat of a packet |
| op_code | input | 2 | Timestamp request code, sampled at the start beat |
| tag_in | input | 16 | Client tag, sampled at the start beat |
| onestep_en | input | 1 | Allows one-step requests |
| timer_in | input | 80 | System timer (seconds in 79:32, ns in 31:0) |
| cap_pulse | input | 1 | A queued packet start crossed the capture point |
| ts_valid | output | 1 | Returned timestamp valid, one cycle |
| ts_tag | output | 16 | Tag paired with the returned timestamp |
| ts_time | output | 80 | Captured timer value |
| onestep_req | output | 1 | One-step insertion request |
| wr_err | output | 1 | Sticky queue overflow flag |
| rd_err | output | 1 | Sticky queue underflow flag |

## Verification
A bad read or write pointer shows up at the first `ts_valid` after the fault: the tag returned is wrong or out of order. A bad occupancy count shows up in two ways. The first is an error flag that rises early. The second is a missing error flag when the ninth push or the empty capture arrives. A bad decode of the request code shows up one cycle after the start beat, in `onestep_req`, or at the next capture, as an extra or missing queued tag.

// File: rtl/ptp_tx_stamp.sv
module ptp_tx_stamp #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 16,
  parameter int TS_W  = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic             pkt_sop,
  input  logic [1:0]       op_code,
  input  logic [TAG_W-1:0] tag_in,
  input  logic             onestep_en,
  input  logic [TS_W-1:0]  timer_in,
  input  logic             cap_pulse,
  output logic             ts_valid,
  output logic [TAG_W-1:0] ts_tag,
  output logic [TS_W-1:0]  ts_time,
  output logic             onestep_req,
  output logic             wr_err,
  output logic             rd_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [TAG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;

  wire start    = pkt_valid & pkt_sop;
  wire push_req = start & (op_code == 2'b10);
  wire empty    = (count == '0);
  wire full     = (count == CW'(DEPTH));
  wire pop      = cap_pulse & ~empty;
  wire push     = push_req & (~full | pop);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= tag_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      ts_valid    <= 1'b0;
      ts_tag      <= '0;
      ts_time     <= '0;
      onestep_req <= 1'b0;
      wr_err      <= 1'b0;
      rd_err      <= 1'b0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      count       <= count + CW'(push) - CW'(pop);
      ts_valid    <= pop;
      if (pop) begin
        ts_tag  <= mem[rd_ptr];
        ts_time <= timer_in;
      end
      onestep_req <= start & (op_code == 2'b01) & onestep_en;
      if (push_req & ~push)  wr_err <= 1'b1;
      if (cap_pulse & empty) rd_err <= 1'b1;
    end
  end

  AST_WR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) wr_err |=> wr_err); // R10
  AST_RD_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rd_err |=> rd_err); // R10
  AST_NO_VALID_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pulse && count == '0) |=> !ts_valid); // R9
  AST_TIME_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pulse && count != '0) |=> (ts_valid && ts_time == $past(timer_in))); // R6
  AST_ONESTEP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_sop && op_code == 2'b01 && !onestep_en) |=> !onestep_req); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R7
endmodule

// File: tb/test_ptp_tx_stamp.sv
module test_ptp_tx_stamp;
  logic clk = 0, rst_n = 0;
  logic pkt_valid = 0, pkt_sop = 0, onestep_en = 0, cap_pulse = 0;
  logic [1:0] op_code = 0;
  logic [15:0] tag_in = 0;
  logic [79:0] timer_in = 0;
  logic ts_valid, onestep_req, wr_err, rd_err;
  logic [15:0] ts_tag;
  logic [79:0] ts_time;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [79:0] last_t;

  always #2 clk = ~clk;

  ptp_tx_stamp i_ptp_tx_stamp (.clk, .rst_n, .pkt_valid, .pkt_sop, .op_code, .tag_in,
    .onestep_en, .timer_in, .cap_pulse, .ts_valid, .ts_tag, .ts_time, .onestep_req,
    .wr_err, .rd_err);

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle; on return the outputs reflect that cycle's clock edge.
  task automatic step(input bit v, input bit s, input logic [1:0] op, input logic [15:0] tg, input bit cp);
    pkt_valid = v; pkt_sop = s; op_code = op; tag_in = tg; cap_pulse = cp;
    cyc++;
    timer_in = {48'(cyc * 3 + 100), 32'(cyc * 17 + 5)};
    last_t = timer_in;
    @(negedge clk);
  endtask

  task automatic idle(); step(0, 0, 2'b00, 16'h0, 0); endtask

  task automatic expect_ts(input logic [15:0] tg, input string req);
    logic [79:0] t;
    step(0, 0, 2'b00, 16'h0, 1);
    t = last_t;
    chk(ts_valid === 1'b1, req, 80'(ts_valid), 80'd1);
    chk(ts_tag === tg, req, 80'(ts_tag), 80'(tg));
    chk(ts_time === t, "R6", ts_time, t);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(!ts_valid && !onestep_req && !wr_err && !rd_err, "R1", 80'({ts_valid, onestep_req, wr_err, rd_err}), 0);
    rst_n = 1;
    idle();
    chk(!ts_valid && !onestep_req && !wr_err && !rd_err, "R1", 80'({ts_valid, onestep_req, wr_err, rd_err}), 0);

    // Sweep every code under both enable values (R3 R4 R5)
    for (int op = 0; op < 4; op++) begin
      for (int en = 0; en < 2; en++) begin
        logic [15:0] tg;
        tg = 16'h1000 + 16'(op * 2 + en);
        onestep_en = en[0];
        step(1, 1, 2'(op), tg, 0);
        chk(onestep_req === (op == 1 && en == 1), (op == 1) ? "R4" : "R3", 80'(onestep_req), 80'(op == 1 && en == 1));
        idle();
        chk(onestep_req === 1'b0, "R4", 80'(onestep_req), 0);
        step(1, 1, 2'b10, 16'hBEEF, 0);
        chk(onestep_req === 1'b0, "R5", 80'(onestep_req), 0);
        if (op == 2) begin
          expect_ts(tg, "R5");
          chk(ts_valid === 1'b1, "R5", 80'(ts_valid), 1);
        end
        expect_ts(16'hBEEF, (op == 2) ? "R7" : "R3");
        idle();
        chk(ts_valid === 1'b0, "R6", 80'(ts_valid), 0);
      end
    end

    // Fill to depth and return in order (R7)
    for (int i = 0; i < 8; i++) step(1, 1, 2'b10, 16'(16'h2000 + i * 7), 0);
    chk(wr_err === 1'b0, "R7", 80'(wr_err), 0);
    for (int i = 0; i < 8; i++) expect_ts(16'(16'h2000 + i * 7), "R7");

    // Push and pop in the same cycle when full: allowed (R8)
    for (int i = 0; i < 8; i++) step(1, 1, 2'b10, 16'(16'h3000 + i), 0);
    step(1, 1, 2'b10, 16'h3008, 1);
    chk(ts_tag === 16'h3000, "R7", 80'(ts_tag), 80'h3000);
    chk(wr_err === 1'b0, "R8", 80'(wr_err), 0);
    // Overflow: ninth tag discarded (R8)
    step(1, 1, 2'b10, 16'h3FFF, 0);
    chk(wr_err === 1'b1, "R8", 80'(wr_err), 1);
    for (int i = 1; i < 9; i++) expect_ts(16'(16'h3000 + i), "R8");
    chk(rd_err === 1'b0, "R9", 80'(rd_err), 0);

    // Non-start beats ignored (R2), then empty capture (R9)
    step(1, 0, 2'b10, 16'h4444, 0);
    step(0, 1, 2'b10, 16'h5555, 0);
    onestep_en = 1;
    step(1, 0, 2'b01, 16'h6666, 0);
    chk(onestep_req === 1'b0, "R2", 80'(onestep_req), 0);
    step(0, 0, 2'b00, 16'h0, 1);
    chk(ts_valid === 1'b0, "R2", 80'(ts_valid), 0);
    chk(rd_err === 1'b1, "R9", 80'(rd_err), 1);

    // Sticky until reset (R10)
    for (int i = 0; i < 5; i++) idle();
    chk(wr_err === 1'b1 && rd_err === 1'b1, "R10", 80'({wr_err, rd_err}), 80'd3);
    rst_n = 0;
    idle();
    rst_n = 1;
    idle();
    chk(wr_err === 1'b0 && rd_err === 1'b0, "R10", 80'({wr_err, rd_err}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule